// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a synthesizable behavioural model of a pipelined synchronous SRAM that needs no idle cycles when the bus changes direction. Every input is sampled on the rising clock edge. Read data leaves through two register stages. Write data follows its address by two enabled edges, so the bus carries one stream of commands with no gaps. The model holds each write address and byte mask in a two-stage pipeline until the matching data arrives. A read of an address whose write is committing in that same cycle receives the incoming bytes merged over the stored word.

A cycle begins when the load strobe is low. Such a cycle is a read or a write only if all three chip enables agree; any other combination deselects the device. While the load strobe is high, the previous operation continues at the next address of a four-beat burst. The burst order is either linear or interleaved. The clock-enable input and the power-down input both freeze every register for the edges at which they are active. The output-enable input gates the data pins asynchronously and does not touch the pipeline.

The word is made of LANES lanes of LANE_W bits; the default is four lanes of nine bits. The depth is a parameter with a default of 256 words.

Top module: `zt_sram`

## Requirements
- R1: A load cycle (`adv_n`=0) is a read or a write only when `ce1_n`=0, `ce2`=1 and `ce3_n`=0. Any other combination is a deselect: it produces no read data (`q_valid`=0 for that slot) and changes no stored word.
- R2: A read sampled at enabled edge k puts the word on `q` with `q_valid`=1 after enabled edge k+2. Slots that hold a write, a deselect or idle give `q_valid`=0 and `q`=0.
- R3: A write sampled at enabled edge k takes its data from `d` at enabled edge k+2. Only the lanes whose `bw_n` bit is 0 are updated; lane i occupies bits [LANE_W*i+LANE_W-1 : LANE_W*i].
- R4: A read issued in any cycle after a write returns that write's data, including a read in the very next cycle. When the write was partial, the read returns the written lanes merged with the lanes stored before.
- R5: While `cke_n`=1, no register changes: addresses, both pipelines, `q` and `q_valid` hold, and inputs on those edges are ignored.
- R6: While `pd`=1, the block performs no operation and all state holds, exactly as for R5. A write command presented then leaves memory unchanged.
- R7: With `burst_linear`=1, each cycle with `adv_n`=1 repeats the previous operation. Its address keeps the upper bits of the loaded base, and its two low bits are (base + n) mod 4 for the n-th advance.
- R8: With `burst_linear`=0, the two low address bits of the n-th advance are base XOR n.
- R9: Burst writes sample `bw_n` anew on every beat. Advance cycles that follow a deselect remain deselects.
- R10: `oe_n`=1 forces `q` to zero at once, without changing `q_valid` or the pipeline contents.
- R11: After reset, `q_valid`=0, `q`=0 and no operation is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke_n | input | 1 | Clock enable, active low |
| pd | input | 1 | Power-down, active high |
| adv_n | input | 1 | Low: load a new cycle; high: advance the burst |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Low: write, high: read (sampled on load) |
| bw_n | input | LANES | Per-lane write enables, active low |
| addr | input | AW | Word address |
| burst_linear | input | 1 | Burst order: 1 linear, 0 interleaved |
| oe_n | input | 1 | Asynchronous output enable, active low |
| d | input | LANES*LANE_W | Write data, two enabled edges after its address |
| q | output | LANES*LANE_W | Registered read data |
| q_valid | output | 1 | Marks read data on `q` |

## Verification
An address or mask stage that slips by a cycle writes the wrong word or lanes. A missing forwarding path returns stale data to the read placed right behind a write. Either fault shows on `q` two enabled edges after the affected read. A burst counter that goes wrong misplaces data, and the fault shows when the burst is read back by single reads. A freeze that leaks shows as `q` moving during a stalled edge, or as write data that lands one beat off.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;
endpackage

// File: rtl/zt_burst_gen.sv
module zt_burst_gen #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic          load_i,
  input  logic          linear_i,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] base_q;
  logic [1:0]    cnt_q;
  logic [1:0]    cnt_nx;
  logic [1:0]    ofs;

  assign cnt_nx = cnt_q + 2'd1;
  assign ofs    = linear_i ? (base_q[1:0] + cnt_nx) : (base_q[1:0] ^ cnt_nx);
  assign addr_o = load_i ? addr_i : {base_q[AW-1:2], ofs};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else if (en_i) begin
      if (load_i) begin
        base_q <= addr_i;
        cnt_q  <= '0;
      end else begin
        cnt_q  <= cnt_nx;
      end
    end
  end

  // R7 / R8: the burst base is kept while beats advance
  assert_base_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    en_i && !load_i |=> $stable(base_q));
endmodule

// File: rtl/zt_write_pipe.sv
module zt_write_pipe #(
  parameter int AW    = 8,
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             issue_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [LANES-1:0] bw_n_i,
  output logic             commit_o,
  output logic [AW-1:0]    commit_addr_o,
  output logic [LANES-1:0] commit_mask_o
);
  logic             s1_v, s2_v;
  logic [AW-1:0]    s1_a, s2_a;
  logic [LANES-1:0] s1_m, s2_m;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v <= 1'b0; s1_a <= '0; s1_m <= '0;
      s2_v <= 1'b0; s2_a <= '0; s2_m <= '0;
    end else if (en_i) begin
      s1_v <= issue_i;
      s1_a <= addr_i;
      s1_m <= ~bw_n_i;
      s2_v <= s1_v;
      s2_a <= s1_a;
      s2_m <= s1_m;
    end
  end

  assign commit_o      = s2_v;
  assign commit_addr_o = s2_a;
  assign commit_mask_o = s2_m;

  // R3: a captured write reaches the data stage on the next enabled edge
  assert_wr_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
    en_i && s1_v |=> s2_v && (s2_a == $past(s1_a)) && (s2_m == $past(s1_m)));
endmodule

// File: rtl/zt_sram_array.sv
module zt_sram_array #(
  parameter int DEPTH  = 256,
  parameter int AW     = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  parameter int W      = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [LANES-1:0] wmask_i,
  input  logic [W-1:0]     wdata_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [W-1:0]     rdata_o
);
  logic hit;
  assign hit = we_i && (waddr_i == raddr_i);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (we_i && wmask_i[l]) mem[waddr_i] <= wdata_i[l*LANE_W +: LANE_W];
    end

    // a lane committing this cycle is forwarded over the stored copy
    assign rdata_o[l*LANE_W +: LANE_W] = (hit && wmask_i[l]) ?
      wdata_i[l*LANE_W +: LANE_W] : mem[raddr_i];
  end
endmodule

// File: rtl/zt_sram.sv
module zt_sram
  import zt_sram_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  parameter int AW     = $clog2(DEPTH),
  parameter int W      = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cke_n,
  input  logic             pd,
  input  logic             adv_n,
  input  logic             ce1_n,
  input  logic             ce2,
  input  logic             ce3_n,
  input  logic             we_n,
  input  logic [LANES-1:0] bw_n,
  input  logic [AW-1:0]    addr,
  input  logic             burst_linear,
  input  logic             oe_n,
  input  logic [W-1:0]     d,
  output logic [W-1:0]     q,
  output logic             q_valid
);
  logic en, sel, load;
  op_e  op_cur, op_q;
  logic [AW-1:0] cur_addr;

  logic             wr_commit;
  logic [AW-1:0]    wr_addr;
  logic [LANES-1:0] wr_mask;
  logic [W-1:0]     arr_rd;

  logic          rp1_v, rp2_v, qv_q;
  logic [AW-1:0] rp1_a;
  logic [W-1:0]  rp2_d, q_q;

  assign en   = !cke_n && !pd;
  assign sel  = !ce1_n && ce2 && !ce3_n;
  assign load = !adv_n;

  always_comb begin
    if (load) op_cur = sel ? (we_n ? OP_READ : OP_WRITE) : OP_IDLE;
    else      op_cur = op_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  op_q <= OP_IDLE;
    else if (en) op_q <= op_cur;
  end

  zt_burst_gen #(.AW(AW)) u_burst (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_i     (en),
    .load_i   (load),
    .linear_i (burst_linear),
    .addr_i   (addr),
    .addr_o   (cur_addr)
  );

  zt_write_pipe #(.AW(AW), .LANES(LANES)) u_wpipe (
    .clk           (clk),
    .rst_n         (rst_n),
    .en_i          (en),
    .issue_i       (op_cur == OP_WRITE),
    .addr_i        (cur_addr),
    .bw_n_i        (bw_n),
    .commit_o      (wr_commit),
    .commit_addr_o (wr_addr),
    .commit_mask_o (wr_mask)
  );

  zt_sram_array #(.DEPTH(DEPTH), .AW(AW), .LANES(LANES), .LANE_W(LANE_W), .W(W)) u_array (
    .clk     (clk),
    .we_i    (en && wr_commit),
    .waddr_i (wr_addr),
    .wmask_i (wr_mask),
    .wdata_i (d),
    .raddr_i (rp1_a),
    .rdata_o (arr_rd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rp1_v <= 1'b0; rp1_a <= '0;
      rp2_v <= 1'b0; rp2_d <= '0;
      qv_q  <= 1'b0; q_q   <= '0;
    end else if (en) begin
      rp1_v <= (op_cur == OP_READ);
      rp1_a <= cur_addr;
      rp2_v <= rp1_v;
      rp2_d <= rp1_v ? arr_rd : '0;
      qv_q  <= rp2_v;
      q_q   <= rp2_d;
    end
  end

  assign q       = oe_n ? '0 : q_q;
  assign q_valid = qv_q;

  // R5 and R6: a disabled edge leaves the output stage untouched
  assert_freeze_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(q_q) && $stable(qv_q));

  assert_desel_noread_R1: assert property (@(posedge clk) disable iff (!rst_n)
    en && load && !sel |=> !rp1_v);

  assert_read_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    en && rp2_v |=> qv_q);
endmodule

// File: tb/zt_sram_tb.sv
module zt_sram_tb;
  localparam int CLK_P = 8;
  localparam logic [2:0] ON = 3'b010; // {ce1_n, ce2, ce3_n}

  logic clk = 1'b0;
  logic rst_n, cke_n, pd, adv_n, ce1_n, ce2, ce3_n, we_n, burst_linear, oe_n;
  logic [3:0]  bw_n;
  logic [7:0]  addr;
  logic [35:0] d, q;
  logic        q_valid;

  always #(CLK_P/2) clk = ~clk;

  zt_sram u_dut (
    .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .pd(pd), .adv_n(adv_n),
    .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .we_n(we_n), .bw_n(bw_n),
    .addr(addr), .burst_linear(burst_linear), .oe_n(oe_n), .d(d),
    .q(q), .q_valid(q_valid)
  );

  typedef struct {
    int          due;
    bit          vld;
    logic [35:0] data;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  logic [35:0] ref_mem [256];
  logic [35:0] wq [2];
  int  n_chk = 0, n_fail = 0, mon_edges = 0;
  bit  done = 0;
  int  b_op = 0;           // 0 idle, 1 read, 2 write
  logic [7:0] b_base = '0;
  logic [1:0] b_cnt = '0;

  function automatic logic [35:0] mk(input int s);
    logic [31:0] h;
    h = 32'(s) * 32'h9E3779B1;
    return {h[7:4], h ^ 32'h13572468};
  endfunction

  task automatic check(input string tag, input logic [36:0] act, input logic [36:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_sim();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // driver: one enabled cycle; reference model updated in issue order
  task automatic cmd(input logic a_n, input logic [2:0] ce, input logic w_n,
                     input logic [7:0] a, input logic [3:0] bw, input logic [35:0] wd,
                     input string tag);
    int op; logic [7:0] ea; logic [35:0] m;
    @(negedge clk);
    cke_n = 0; pd = 0; adv_n = a_n; {ce1_n, ce2, ce3_n} = ce;
    we_n = w_n; addr = a; bw_n = bw; d = wq[1];
    if (!a_n) begin
      op = (ce == ON) ? (w_n ? 1 : 2) : 0;
      b_base = a; b_cnt = 0; ea = a;
    end else begin
      op = b_op; b_cnt = b_cnt + 2'd1;
      ea = {b_base[7:2], burst_linear ? (b_base[1:0] + b_cnt) : (b_base[1:0] ^ b_cnt)};
    end
    b_op = op;
    if (op == 2) begin
      m = ref_mem[ea];
      for (int l = 0; l < 4; l++) if (!bw[l]) m[l*9 +: 9] = wd[l*9 +: 9];
      ref_mem[ea] = m;
    end
    wq[1] = wq[0];
    wq[0] = (op == 2) ? wd : 36'h0;
    if (op == 1) sb.push_back('{mon_edges + 3, 1'b1, ref_mem[ea], tag});
    else         sb.push_back('{mon_edges + 3, 1'b0, 36'h0, tag});
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cmd(1'b0, 3'b110, 1'b1, 8'h0, 4'hF, 36'h0, "R2");
  endtask

  // a disabled edge carrying a write to a live address and junk data
  task automatic stall(input bit use_pd, input logic [7:0] a, input string tag);
    logic [35:0] pq; logic pv;
    @(negedge clk);
    pq = q; pv = q_valid;
    cke_n = !use_pd; pd = use_pd; adv_n = 0; {ce1_n, ce2, ce3_n} = ON;
    we_n = 0; addr = a; bw_n = 4'h0; d = 36'hA5A5A5A5A;
    @(posedge clk); #(CLK_P/4);
    check(tag, {pv, pq}, {q_valid, q});
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      bit en_now;
      @(posedge clk);
      en_now = rst_n && !cke_n && !pd;
      if (en_now) mon_edges++;
      #(CLK_P/4);
      if (en_now && sb.size() > 0 && sb[0].due == mon_edges) begin
        exp_t e;
        e = sb.pop_front();
        n_chk++;
        if (q_valid !== e.vld || q !== e.data) begin
          n_fail++;
          $display("FAIL %s: q_valid=%b q=%h expected q_valid=%b q=%h",
                   e.tag, q_valid, q, e.vld, e.data);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    finish_sim();
  end

  initial begin
    wq[0] = '0; wq[1] = '0;
    rst_n = 0; cke_n = 0; pd = 0; adv_n = 1; ce1_n = 1; ce2 = 0; ce3_n = 1;
    we_n = 1; bw_n = 4'hF; addr = '0; burst_linear = 1; oe_n = 0; d = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1 check("R11", {q_valid, q}, 37'h0);

    // R3 / R2: full writes then reads
    for (int i = 0; i < 6; i++) cmd(1'b0, ON, 1'b0, 8'(i * 9 + 1), 4'h0, mk(i), "R3");
    for (int i = 0; i < 6; i++) cmd(1'b0, ON, 1'b1, 8'(i * 9 + 1), 4'hF, 36'h0, "R2");

    // R4: zero-turnaround, read right behind write, partial merge
    cmd(1'b0, ON, 1'b0, 8'd40, 4'h0, mk(100), "R4");
    cmd(1'b0, ON, 1'b1, 8'd40, 4'hF, 36'h0, "R4");
    cmd(1'b0, ON, 1'b0, 8'd40, 4'b1010, mk(101), "R4");
    cmd(1'b0, ON, 1'b1, 8'd40, 4'hF, 36'h0, "R4");
    cmd(1'b0, ON, 1'b0, 8'd41, 4'h0, mk(102), "R4");
    cmd(1'b0, ON, 1'b0, 8'd41, 4'b0111, mk(103), "R4");
    cmd(1'b0, ON, 1'b1, 8'd41, 4'hF, 36'h0, "R4");
    cmd(1'b0, ON, 1'b1, 8'd40, 4'hF, 36'h0, "R4");

    // R1: deselect combinations with write and read intent
    cmd(1'b0, 3'b110, 1'b0, 8'd40, 4'h0, mk(200), "R1");
    cmd(1'b0, 3'b000, 1'b0, 8'd40, 4'h0, mk(201), "R1");
    cmd(1'b0, 3'b011, 1'b1, 8'd40, 4'h0, mk(202), "R1");
    idle(2);
    cmd(1'b0, ON, 1'b1, 8'd40, 4'hF, 36'h0, "R1");

    // R5: clock-enable stall between write address and data
    cmd(1'b0, ON, 1'b0, 8'd50, 4'h0, mk(300), "R5");
    stall(1'b0, 8'd40, "R5");
    stall(1'b0, 8'd40, "R5");
    cmd(1'b0, ON, 1'b1, 8'd50, 4'hF, 36'h0, "R5");
    cmd(1'b0, ON, 1'b1, 8'd40, 4'hF, 36'h0, "R5");

    // R6: power-down ignores a write command
    cmd(1'b0, ON, 1'b0, 8'd60, 4'h0, mk(400), "R6");
    idle(2);
    stall(1'b1, 8'd60, "R6");
    cmd(1'b0, ON, 1'b1, 8'd60, 4'hF, 36'h0, "R6");

    // R7: linear burst, base low bits = 2 -> 70,71,68,69
    @(negedge clk); burst_linear = 1;
    cmd(1'b0, ON, 1'b0, 8'd70, 4'h0, mk(500), "R7");
    for (int i = 1; i < 4; i++) cmd(1'b1, ON, 1'b0, 8'd0, 4'h0, mk(500 + i), "R7");
    idle(2);
    for (int i = 68; i < 72; i++) cmd(1'b0, ON, 1'b1, 8'(i), 4'hF, 36'h0, "R7");
    cmd(1'b0, ON, 1'b1, 8'd71, 4'hF, 36'h0, "R7");
    for (int i = 1; i < 4; i++) cmd(1'b1, 3'b110, 1'b0, 8'd0, 4'h0, 36'h0, "R7");

    // R8: interleaved burst write base 81, read burst base 83
    idle(1);
    @(negedge clk); burst_linear = 0;
    cmd(1'b0, ON, 1'b0, 8'd81, 4'h0, mk(600), "R8");
    for (int i = 1; i < 4; i++) cmd(1'b1, ON, 1'b0, 8'd0, 4'h0, mk(600 + i), "R8");
    cmd(1'b0, ON, 1'b1, 8'd83, 4'hF, 36'h0, "R8");
    for (int i = 1; i < 4; i++) cmd(1'b1, ON, 1'b0, 8'd0, 4'h0, 36'h0, "R8");
    for (int i = 80; i < 84; i++) cmd(1'b0, ON, 1'b1, 8'(i), 4'hF, 36'h0, "R8");

    // R9: per-beat byte enables in a burst; advance after deselect stays idle
    @(negedge clk); burst_linear = 1;
    cmd(1'b0, ON, 1'b0, 8'd88, 4'h0, mk(700), "R9");
    cmd(1'b1, ON, 1'b0, 8'd0, 4'b1110, mk(701), "R9");
    cmd(1'b1, ON, 1'b0, 8'd0, 4'b0101, mk(702), "R9");
    cmd(1'b1, ON, 1'b0, 8'd0, 4'b1111, mk(703), "R9");
    cmd(1'b0, 3'b000, 1'b0, 8'd88, 4'h0, mk(704), "R9");
    cmd(1'b1, ON, 1'b0, 8'd0, 4'h0, mk(705), "R9");
    cmd(1'b1, ON, 1'b1, 8'd0, 4'h0, mk(706), "R9");
    for (int i = 88; i < 92; i++) cmd(1'b0, ON, 1'b1, 8'(i), 4'hF, 36'h0, "R9");

    // R10: output enable during a stall that holds valid data
    cmd(1'b0, ON, 1'b1, 8'd40, 4'hF, 36'h0, "R10");
    idle(2);
    stall(1'b0, 8'd0, "R10");
    @(negedge clk); oe_n = 1;
    #1 check("R10", {q_valid, q}, {1'b1, 36'h0});
    oe_n = 0;
    #1 check("R10", {q_valid, q}, {1'b1, ref_mem[40]});
    idle(3);

    repeat (4) @(posedge clk);
    if (sb.size() != 0) check("R2", 37'(sb.size()), 37'h0);
    finish_sim();
  end
endmodule